// File: doc/BRIEF.md
# Clock Alarm Edge-Event Register

This block sits beside a redundant telecom clock PLL. It watches four alarm levels that arrive asynchronously: primary reference lost, secondary reference lost, holdover active and loss of lock. Each level passes through a synchronizer. The synchronized levels are visible in a live status byte. Every transition of every alarm, in either direction, is captured as its own sticky bit in an 8-bit event byte.

A dedicated, unshared level interrupt stays high while any event bit is pending. Software reads the event byte over a small byte-wide read port and so learns both directions of every change since its last visit. That read also clears the byte. An edge that arrives in the very cycle of the clearing read is kept, so no change is lost between two reads.

Read data is combinational from the address. A read takes effect (the clear) at the rising clock edge on which `rd_en_i` is high with the event address selected.

Top module: `clk_alarm_event_reg`

## Requirements
- R1: At the status address (0), read data bits 7, 6, 5 and 4 show the synchronized levels of `alarm_i[0]` (primary lost), `alarm_i[1]` (secondary lost), `alarm_i[2]` (holdover) and `alarm_i[3]` (unlock), in that order. Bits 3 to 0 read as zero.
- R2: At the event address (1), bit 2k is set by a 0-to-1 change of `alarm_i[k]` and bit 2k+1 by a 1-to-0 change, for k = 0 (primary), 1 (secondary), 2 (holdover) and 3 (unlock).
- R3: An event bit, once set, stays set until a clearing read. Events from other alarms accumulate alongside it.
- R4: A clock edge with `rd_en_i` high and the event address selected clears all event bits. The read data in that cycle shows the contents before the clear.
- R5: An edge detected at the same clock edge as a clearing read is recorded and stays set after the clear.
- R6: `irq_o` is a registered output. It is high exactly while the event byte is nonzero, and it falls after a clearing read when no new edge arrived.
- R7: An alarm level sampled at clock edge k shows in the status byte after edge k+1, and its edge shows in the event byte after edge k+2.
- R8: After reset, the event byte is zero and `irq_o` is low. Alarm levels that are held steady through reset and after it produce no event.
- R9: Any other address reads as zero. A read there, or a cycle with `rd_en_i` low, clears nothing.
- R10: A pulse of an alarm that lasts at least one cycle at each level between two reads sets both the rising and the falling bit of that alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alarm_i | input | 4 | Asynchronous alarm levels: 0 primary lost, 1 secondary lost, 2 holdover, 3 unlock |
| rd_addr_i | input | 2 | Register address: 0 status, 1 events |
| rd_en_i | input | 1 | Read strobe; with address 1 it clears the event byte |
| rd_data_o | output | 8 | Read data for the selected address |
| irq_o | output | 1 | Level interrupt, high while any event is pending |

## Verification
The hardest case to reach from the ports is an edge that completes its path through the synchronizer at exactly the clock edge of a clearing read. The stimulus changes an alarm at a known falling edge and counts two further cycles of synchronizer and history latency. It then places the read strobe on that cycle, so the clear and the set land together. The second hard case is a reset with alarms already high, which would show a spurious edge if the history were filled too early. The bench resets with asserted alarms and checks that the event byte stays empty. A reference model built from queued input samples then follows a long pseudo-random phase with arbitrary toggles and reads.

// File: rtl/cae_pkg.sv
package cae_pkg;
    localparam int NUM_ALARMS = 4;
    localparam int EVT_W      = 2 * NUM_ALARMS;
    localparam int BYTE_W     = 8;

    typedef struct packed {
        logic [EVT_W-1:0] events;
        logic             irq;
    } evt_state_t;
endpackage

// File: rtl/cae_sync.sv
module cae_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cae_edge.sv
module cae_edge #(
    parameter int WIDTH  = 4,
    parameter int WARM_N = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    localparam int CNT_W = $clog2(WARM_N + 1);
    localparam logic [CNT_W-1:0] WARM_DONE = CNT_W'(WARM_N);

    typedef struct packed {
        logic [WIDTH-1:0] hist;
        logic [CNT_W-1:0] warm;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        armed;

    always_comb begin
        st_d      = st_q;
        armed     = (st_q.warm == WARM_DONE);
        st_d.hist = lvl_i;
        if (!armed) st_d.warm = st_q.warm + 1'b1;
        rise_o = armed ? (lvl_i & ~st_q.hist) : '0;
        fall_o = armed ? (~lvl_i & st_q.hist) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R2: one alarm cannot rise and fall in the same cycle
    a_r2_single_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_o & fall_o) == '0);
    // R8: no edge is reported while the history is still filling
    a_r8_warm_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.warm != WARM_DONE) |-> (rise_o == '0 && fall_o == '0));
endmodule

// File: rtl/cae_evt.sv
module cae_evt
    import cae_pkg::*;
#(
    parameter int NUM = NUM_ALARMS
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NUM-1:0] rise_i,
    input  logic [NUM-1:0] fall_i,
    input  logic           clr_i,
    output logic [2*NUM-1:0] events_o,
    output logic           irq_o
);
    localparam int W = 2 * NUM;

    typedef struct packed {
        logic [W-1:0] events;
        logic         irq;
    } st_t;

    st_t          st_d, st_q;
    logic [W-1:0] set_vec;

    for (genvar k = 0; k < NUM; k++) begin : g_pair
        assign set_vec[2*k]   = rise_i[k];
        assign set_vec[2*k+1] = fall_i[k];
    end

    always_comb begin
        st_d        = st_q;
        st_d.events = (clr_i ? '0 : st_q.events) | set_vec;
        st_d.irq    = |st_d.events;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign events_o = st_q.events;
    assign irq_o    = st_q.irq;

    // R5: a new edge always survives into the next state, even with a clear
    a_r5_no_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_vec != '0 |=> (st_q.events & $past(set_vec)) == $past(set_vec));
    // R4: a clear with no new edge empties the byte
    a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && set_vec == '0) |=> st_q.events == '0);
    // R3: without a clear, pending bits stay
    a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> (st_q.events & $past(st_q.events)) == $past(st_q.events));
    // R6: interrupt mirrors a nonempty event byte
    a_r6_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (events_o != '0));
endmodule

// File: rtl/clk_alarm_event_reg.sv
module clk_alarm_event_reg
    import cae_pkg::*;
#(
    parameter int              ADDR_W      = 2,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 2'd0,
    parameter logic [ADDR_W-1:0] EVENT_ADDR  = 2'd1,
    parameter int              SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_ALARMS-1:0] alarm_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    input  logic                  rd_en_i,
    output logic [BYTE_W-1:0]     rd_data_o,
    output logic                  irq_o
);
    localparam int WARM_N = SYNC_STAGES + 1;

    logic [NUM_ALARMS-1:0] lvl, rise, fall;
    logic [EVT_W-1:0]      events;
    logic [BYTE_W-1:0]     status;
    logic                  clr;

    cae_sync #(.WIDTH(NUM_ALARMS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .async_i(alarm_i), .sync_o(lvl));

    cae_edge #(.WIDTH(NUM_ALARMS), .WARM_N(WARM_N)) u_edge (
        .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl),
        .rise_o(rise), .fall_o(fall));

    assign clr = rd_en_i && (rd_addr_i == EVENT_ADDR);

    cae_evt #(.NUM(NUM_ALARMS)) u_evt (
        .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall),
        .clr_i(clr), .events_o(events), .irq_o(irq_o));

    always_comb begin
        status = '0;
        for (int k = 0; k < NUM_ALARMS; k++) begin
            status[BYTE_W-1-k] = lvl[k];
        end
    end

    always_comb begin
        if (rd_addr_i == STATUS_ADDR)     rd_data_o = status;
        else if (rd_addr_i == EVENT_ADDR) rd_data_o = events;
        else                              rd_data_o = '0;
    end

    // R1: low nibble of the status byte is always zero
    a_r1_low_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i == STATUS_ADDR) |-> rd_data_o[3:0] == 4'h0);
    // R9: unused addresses read zero
    a_r9_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i != STATUS_ADDR && rd_addr_i != EVENT_ADDR) |-> rd_data_o == '0);
endmodule

// File: tb/tb_clk_alarm_event_reg.sv
`timescale 1ns/1ps
module tb_clk_alarm_event_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] alarm = 4'b0;
    logic [1:0] rd_addr = 2'd0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    always #2.5 clk = ~clk;

    clk_alarm_event_reg dut (
        .clk_i(clk), .rst_ni(rst_n), .alarm_i(alarm), .rd_addr_i(rd_addr),
        .rd_en_i(rd_en), .rd_data_o(rd_data), .irq_o(irq));

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R8";

    // Reference model: queue of input samples taken at each rising edge
    logic [3:0] hq[$];
    int         n_edges;
    logic [7:0] ev_m;
    logic       irq_m;
    logic [3:0] lvl_m;
    logic       clr_m;

    always @(posedge clk) begin
        if (!rst_n) begin
            hq.delete(); n_edges = 0; ev_m = 0; irq_m = 0; lvl_m = 0;
        end else begin
            clr_m = rd_en && (rd_addr == 2'd1);
            hq.push_front(alarm);
            if (hq.size() > 4) void'(hq.pop_back());
            n_edges++;
            if (clr_m) ev_m = 0;
            if (n_edges >= 4) begin
                for (int k = 0; k < 4; k++) begin
                    if (hq[2][k] && !hq[3][k]) ev_m[2*k]   = 1'b1;
                    if (!hq[2][k] && hq[3][k]) ev_m[2*k+1] = 1'b1;
                end
            end
            irq_m = |ev_m;
            lvl_m = (n_edges >= 2) ? hq[1] : 4'b0;
        end
    end

    function automatic logic [7:0] exp_data();
        case (rd_addr)
            2'd0:    return {lvl_m[0], lvl_m[1], lvl_m[2], lvl_m[3], 4'b0};
            2'd1:    return ev_m;
            default: return 8'h00;
        endcase
    endfunction

    // Compare every cycle, one ns after the falling edge
    always begin
        @(negedge clk); #1;
        if (!done) begin
            string rt;
            logic [7:0] e;
            rt = (rd_addr == 2'd0) ? "R1" : (rd_addr == 2'd1) ? "R2" : "R9";
            e  = exp_data();
            n_cmp++;
            if (rd_data !== e) begin
                n_bad++;
                $display("FAIL %s/%s rd_data addr=%0d actual=%02h expected=%02h t=%0t",
                         rt, tag, rd_addr, rd_data, e, $time);
            end
            n_cmp++;
            if (irq !== irq_m) begin
                n_bad++;
                $display("FAIL R6/%s irq actual=%0b expected=%0b t=%0t",
                         tag, irq, irq_m, $time);
            end
        end
    end

    task automatic tick(int c = 1);
        repeat (c) @(negedge clk);
    endtask

    task automatic rd(logic [1:0] a);
        rd_addr = a; rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        // R8: reset with primary and holdover alarms already high
        alarm = 4'b0101;
        tick(5);
        rst_n = 1'b1;
        tick(10);
        rd_addr = 2'd0; tick(2);
        rd_addr = 2'd1; tick(2);

        // R7 and R2: unlock rises; watch latency on status and events
        tag = "R7";
        alarm[3] = 1'b1;
        rd_addr = 2'd0; tick(2);
        rd_addr = 2'd1; tick(3);
        tag = "R4";
        rd(2'd1); tick(2);

        // R10: primary pulse low then high between reads
        tag = "R10";
        alarm[0] = 1'b0; tick(3);
        alarm[0] = 1'b1; tick(5);
        rd(2'd1); tick(2);

        // R3: accumulate edges of several alarms, no read between
        tag = "R3";
        alarm[1] = 1'b1; tick(4);
        alarm[2] = 1'b0; tick(4);
        alarm = ~alarm;  tick(6);

        // R9: reads at other addresses and idle strobe clear nothing
        tag = "R9";
        rd(2'd2); rd(2'd3); tick(2);
        rd_addr = 2'd1; tick(2);
        rd(2'd1); tick(2);

        // R5: edge arrives exactly at the clearing read edge
        tag = "R5";
        alarm[1] = ~alarm[1];
        tick(2);
        rd(2'd1);
        tick(3);
        rd(2'd1);
        alarm[3] = ~alarm[3];
        tick(2);
        rd(2'd1);
        tick(4);
        rd(2'd1); tick(2);

        // Long mixed phase (R2, R3, R4, R6)
        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) alarm[lfsr[5:4]] = ~alarm[lfsr[5:4]];
            rd_addr = lfsr[7:6];
            rd_en   = (lfsr[11:8] == 4'h5);
            tick();
        end
        rd_en = 1'b0;
        tick(5);
        finish_run();
    end
endmodule